// File: doc/BRIEF.md
# Error-Record Selector Access Gate

This block guards a single 64-bit system register that chooses which error record a processor's record-view registers point at. Each cycle it may receive one access request, described by its five encoding fields, a read/write flag, the current privilege level (0 to 3) and a set of control bits supplied by the more privileged levels. For a request that names this register it decides whether the access goes ahead, is rejected as an undefined instruction, or is diverted to level 2 or level 3 as a trap carrying a syndrome class.

Only the low 16 bits of the register hold state, as a record index. A permitted write loads that index and a permitted read returns it zero-extended to 64 bits. The stored index also drives a multiplexer over a bank of error records, so the rest of the core sees the selected record's contents together with a flag saying that the index lies beyond the implemented records.

The decision is registered: the response appears one clock after the request strobe, and a write changes the stored index on that same clock edge only when the outcome is "perform".

Top module: `errsel_access_gate`

## Requirements
- R1: A request is accepted only when op0=2'b11, op1=3'b000, CRn=4'b0101, CRm=4'b0011 and op2=3'b001; any other encoding yields no response (rsp_vld stays low) and leaves the stored index unchanged.
- R2: For an accepted request, rsp_vld is high in the cycle after req_vld, with rsp_kind encoded 2'b00 = perform, 2'b01 = undefined, 2'b10 = trap to level 2, 2'b11 = trap to level 3; with no request, rsp_vld is low.
- R3: Any access made at privilege level 0 gives undefined.
- R4: A read at level 1 takes the first match of: level 3 present, undefined-first set and level-3 error trap set gives undefined; level 2 active and level-2 error trap set gives trap to level 2; level 2 active, fine-grained traps present, (level 3 absent or its fine-grained enable set) and fine-grained read trap set gives trap to level 2; level 3 present and level-3 error trap set gives undefined if the undefined-select bit is set, else trap to level 3; otherwise perform.
- R5: A write at level 1 uses the R4 order, except that the level-3 write trap bit is tested right after the level-3 error trap bit at both level-3 steps, and the fine-grained step tests the fine-grained write trap instead of the read trap.
- R6: At level 2 only the two level-3 steps of R4 (reads) or R5 (writes) apply, in the same order; otherwise the access is performed.
- R7: Any access at level 3 is performed regardless of the control bits.
- R8: A trap response (rsp_kind 2'b10 or 2'b11) carries rsp_ec = 6'h18; perform and undefined responses carry rsp_ec = 0.
- R9: A performed write loads wdata[15:0] into the stored index, bits [63:16] of the write data are ignored, and a write with any other outcome leaves the index unchanged.
- R10: A performed read returns the stored index in rsp_rdata[15:0] with bits [63:16] zero; any other response returns rsp_rdata = 0.
- R11: After reset the stored index is 0 and rsp_vld is low.
- R12: rec_data shows bank record number sel_idx (bits [i*REC_W +: REC_W] of rec_bank for record i); when sel_idx >= NUM_REC, rec_oor is high and rec_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Access request strobe |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_lvl | input | 2 | Current privilege level |
| req_wdata | input | 64 | Write data |
| l3_present | input | 1 | Level 3 is implemented |
| l2_active | input | 1 | Level 2 is enabled for this context |
| fg_present | input | 1 | Fine-grained traps are implemented |
| l3_undef_first | input | 1 | Level-3 undefined check takes priority |
| l3_undef_sel | input | 1 | Level-3 trap step yields undefined instead of trapping |
| l3_err_trap | input | 1 | Level-3 error-register trap bit |
| l3_err_wr_trap | input | 1 | Level-3 write-only error-register trap bit |
| l2_err_trap | input | 1 | Level-2 error-register trap bit |
| l3_fg_en | input | 1 | Level-3 enable for fine-grained traps |
| fg_rd_trap | input | 1 | Fine-grained read trap bit for this register |
| fg_wr_trap | input | 1 | Fine-grained write trap bit for this register |
| rec_bank | input | NUM_REC*REC_W | Flattened error-record bank |
| rsp_vld | output | 1 | Response valid |
| rsp_kind | output | 2 | Outcome code |
| rsp_ec | output | 6 | Syndrome class for traps |
| rsp_rdata | output | 64 | Read data |
| sel_idx | output | 16 | Stored record index |
| rec_data | output | REC_W | Selected record contents |
| rec_oor | output | 1 | Stored index is out of range |

## Verification
Random requests mix the correct encoding with single-field near misses, all four levels, both directions and all 2048 control-bit combinations, so the read and write priority chains are told apart by cases where only the write-only or fine-grained write bit is set. Directed steps pin the level-3 override with every trap bit set, a blocked write that must not change the index, write data with noisy upper bits, and indices on either side of the record count so the in-range and out-of-range mux paths are separated.

// File: rtl/errsel_access_gate.sv
module errsel_access_gate #(
  parameter int NUM_REC = 8,
  parameter int REC_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_vld,
  input  logic [1:0]               req_op0,
  input  logic [2:0]               req_op1,
  input  logic [3:0]               req_crn,
  input  logic [3:0]               req_crm,
  input  logic [2:0]               req_op2,
  input  logic                     req_wr,
  input  logic [1:0]               req_lvl,
  input  logic [63:0]              req_wdata,
  input  logic                     l3_present,
  input  logic                     l2_active,
  input  logic                     fg_present,
  input  logic                     l3_undef_first,
  input  logic                     l3_undef_sel,
  input  logic                     l3_err_trap,
  input  logic                     l3_err_wr_trap,
  input  logic                     l2_err_trap,
  input  logic                     l3_fg_en,
  input  logic                     fg_rd_trap,
  input  logic                     fg_wr_trap,
  input  logic [NUM_REC*REC_W-1:0] rec_bank,
  output logic                     rsp_vld,
  output logic [1:0]               rsp_kind,
  output logic [5:0]               rsp_ec,
  output logic [63:0]              rsp_rdata,
  output logic [15:0]              sel_idx,
  output logic [REC_W-1:0]         rec_data,
  output logic                     rec_oor
);
  localparam int SEL_W = 16;
  localparam logic [1:0] K_OK = 2'b00, K_UND = 2'b01, K_T2 = 2'b10, K_T3 = 2'b11;
  localparam logic [5:0] TRAP_EC = 6'h18;

  logic hit, l3_hit, fg_hit, go;
  logic [1:0] kind;
  logic [SEL_W-1:0] sel_q;
  logic unused_hi;

  assign unused_hi = ^req_wdata[63:SEL_W];
  assign hit = req_vld && req_op0 == 2'b11 && req_op1 == 3'b000 &&
               req_crn == 4'b0101 && req_crm == 4'b0011 && req_op2 == 3'b001;
  assign l3_hit = l3_present && (l3_err_trap || (req_wr && l3_err_wr_trap));
  assign fg_hit = l2_active && fg_present && (!l3_present || l3_fg_en) &&
                  (req_wr ? fg_wr_trap : fg_rd_trap);

  always_comb begin
    kind = K_OK;
    case (req_lvl)
      2'd0: kind = K_UND;
      2'd1: begin
        if (l3_hit && l3_undef_first)     kind = K_UND;
        else if (l2_active && l2_err_trap) kind = K_T2;
        else if (fg_hit)                   kind = K_T2;
        else if (l3_hit)                   kind = l3_undef_sel ? K_UND : K_T3;
      end
      2'd2: begin
        if (l3_hit && l3_undef_first) kind = K_UND;
        else if (l3_hit)              kind = l3_undef_sel ? K_UND : K_T3;
      end
      default: kind = K_OK;
    endcase
  end

  assign go = hit && kind == K_OK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      rsp_vld   <= 1'b0;
      rsp_kind  <= K_OK;
      rsp_ec    <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_vld   <= hit;
      rsp_kind  <= hit ? kind : K_OK;
      rsp_ec    <= (hit && kind[1]) ? TRAP_EC : '0;
      rsp_rdata <= (go && !req_wr) ? {{(64-SEL_W){1'b0}}, sel_q} : '0;
      if (go && req_wr) sel_q <= req_wdata[SEL_W-1:0];
    end
  end

  assign sel_idx = sel_q;

  always_comb begin
    rec_data = '0;
    for (int i = 0; i < NUM_REC; i++)
      if (sel_q == SEL_W'(i)) rec_data = rec_bank[i*REC_W +: REC_W];
  end
  assign rec_oor = sel_q >= SEL_W'(NUM_REC);

  // R3
  lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && req_lvl == 2'd0 |=> rsp_vld && rsp_kind == K_UND);
  // R7
  lvl3_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && req_lvl == 2'd3 |=> rsp_vld && rsp_kind == K_OK);
  // R8
  trap_ec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && rsp_kind[1] |-> rsp_ec == TRAP_EC);
  // R1
  no_match_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !rsp_vld && $stable(sel_idx));
  // R10
  rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rdata[63:SEL_W] == '0);
  // R12
  oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_oor |-> rec_data == '0);
endmodule

// File: tb/errsel_access_gate_tb.sv
module errsel_access_gate_tb;
  localparam int NUM_REC = 8;
  localparam int REC_W = 32;

  logic clk = 0, rst_n = 0;
  logic req_vld = 0, req_wr = 0;
  logic [1:0] req_op0 = 0, req_lvl = 0;
  logic [2:0] req_op1 = 0, req_op2 = 0;
  logic [3:0] req_crn = 0, req_crm = 0;
  logic [63:0] req_wdata = 0;
  logic [10:0] ctl = 0;
  logic [NUM_REC*REC_W-1:0] rec_bank = 0;
  logic rsp_vld, rec_oor;
  logic [1:0] rsp_kind;
  logic [5:0] rsp_ec;
  logic [63:0] rsp_rdata;
  logic [15:0] sel_idx;
  logic [REC_W-1:0] rec_data;

  int errors = 0, checks = 0;
  logic [15:0] exp_sel = 0;

  always #4 clk = ~clk;

  errsel_access_gate #(.NUM_REC(NUM_REC), .REC_W(REC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld),
    .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
    .req_op2(req_op2), .req_wr(req_wr), .req_lvl(req_lvl), .req_wdata(req_wdata),
    .l3_present(ctl[0]), .l2_active(ctl[1]), .fg_present(ctl[2]),
    .l3_undef_first(ctl[3]), .l3_undef_sel(ctl[4]), .l3_err_trap(ctl[5]),
    .l3_err_wr_trap(ctl[6]), .l2_err_trap(ctl[7]), .l3_fg_en(ctl[8]),
    .fg_rd_trap(ctl[9]), .fg_wr_trap(ctl[10]), .rec_bank(rec_bank),
    .rsp_vld(rsp_vld), .rsp_kind(rsp_kind), .rsp_ec(rsp_ec), .rsp_rdata(rsp_rdata),
    .sel_idx(sel_idx), .rec_data(rec_data), .rec_oor(rec_oor));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Priority chains written step by step from R3-style rules (R4, R5, R6, R7)
  function automatic logic [1:0] model(input logic [1:0] lvl, input logic wr, input logic [10:0] c);
    logic p3, p2, fg, ufirst, usel, t3, tw3, t2, fen, frd, fwr;
    {fwr, frd, fen, t2, tw3, t3, usel, ufirst, fg, p2, p3} = c;
    if (lvl == 2'd0) return 2'b01;
    if (lvl == 2'd3) return 2'b00;
    if (p3 && ufirst && t3) return 2'b01;
    if (wr && p3 && ufirst && tw3) return 2'b01;
    if (lvl == 2'd1) begin
      if (p2 && t2) return 2'b10;
      if (p2 && fg && (!p3 || fen) && (wr ? fwr : frd)) return 2'b10;
    end
    if (p3 && t3) return usel ? 2'b01 : 2'b11;
    if (wr && p3 && tw3) return usel ? 2'b01 : 2'b11;
    return 2'b00;
  endfunction

  function automatic logic [REC_W-1:0] exp_rec(input logic [15:0] s);
    if (s >= NUM_REC) return '0;
    return rec_bank[s*REC_W +: REC_W];
  endfunction

  task automatic check_mux();
    chk("R12 rec_data", 64'(rec_data), 64'(exp_rec(exp_sel)));
    chk("R12 rec_oor", 64'(rec_oor), 64'(exp_sel >= NUM_REC));
  endtask

  // Called at a negedge; samples at the following negedge.
  task automatic issue(input logic good, input logic [13:0] enc, input logic wr,
                       input logic [1:0] lvl, input logic [63:0] wd, input logic [10:0] c);
    logic [1:0] k;
    logic match;
    {req_op0, req_op1, req_crn, req_crm, req_op2} = good ? 16'b11_000_0101_0011_001 : {2'b11, enc};
    match = good || {2'b11, enc} == 16'b11_000_0101_0011_001;
    req_wr = wr; req_lvl = lvl; req_wdata = wd; ctl = c; req_vld = 1;
    k = model(lvl, wr, c);
    @(negedge clk);
    req_vld = 0;
    if (!match) begin
      chk("R1 no response", 64'(rsp_vld), 64'd0);
    end else begin
      chk("R2 rsp_vld", 64'(rsp_vld), 64'd1);
      chk(lvl == 0 ? "R3 kind" : lvl == 3 ? "R7 kind" : lvl == 2 ? "R6 kind" :
          wr ? "R5 kind" : "R4 kind", 64'(rsp_kind), 64'(k));
      chk("R8 ec", 64'(rsp_ec), k[1] ? 64'h18 : 64'h0);
      chk("R10 rdata", rsp_rdata, (k == 2'b00 && !wr) ? {48'd0, exp_sel} : 64'd0);
      if (k == 2'b00 && wr) exp_sel = wd[15:0];
    end
    chk("R9 sel_idx", 64'(sel_idx), 64'(exp_sel));
    check_mux();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NUM_REC; i++) rec_bank[i*REC_W +: REC_W] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11 sel_idx reset", 64'(sel_idx), 64'd0);
    chk("R11 rsp_vld reset", 64'(rsp_vld), 64'd0);
    check_mux();
    // R3 level 0 write with no traps: undefined, no update
    issue(1, 0, 1, 2'd0, 64'h3, 11'd0);
    // R7 level 3 with every control bit set, upper data noise (R9)
    issue(1, 0, 1, 2'd3, 64'hDEAD_BEEF_0000_0005, 11'h7FF);
    issue(1, 0, 0, 2'd3, 64'd0, 11'h7FF);
    // R12 last in-range index then first out-of-range
    issue(1, 0, 1, 2'd3, 64'd7, 11'd0);
    issue(1, 0, 1, 2'd3, 64'd8, 11'd0);
    issue(1, 0, 1, 2'd3, 64'hFFFF, 11'd0);
    // R9 blocked write at level 1 via level-2 trap
    issue(1, 0, 1, 2'd1, 64'd2, 11'b000_1000_0010);
    // R5 write-only trap vs read
    issue(1, 0, 1, 2'd1, 64'd3, 11'b000_0100_0001);
    issue(1, 0, 0, 2'd1, 64'd0, 11'b000_0100_0001);
    // R5 fine-grained write bit only, R4 read unaffected
    issue(1, 0, 1, 2'd1, 64'd4, 11'b100_0000_0110);
    issue(1, 0, 0, 2'd1, 64'd0, 11'b100_0000_0110);
    // R1 near-miss encoding at level 3
    issue(0, 14'b000_0101_0011_011, 1, 2'd3, 64'd1, 11'd0);
    // R2 idle cycle
    @(negedge clk);
    chk("R2 idle rsp_vld", 64'(rsp_vld), 64'd0);
    for (int n = 0; n < 3000; n++) begin
      logic good;
      logic [13:0] enc;
      logic [63:0] wd;
      good = ($urandom % 5) != 0;
      enc = 14'b000_0101_0011_001 ^ (14'd1 << ($urandom % 14));
      wd = {$urandom, $urandom};
      if ($urandom % 2) wd[15:0] = 16'($urandom % 12);
      if ((n % 500) == 0)
        for (int i = 0; i < NUM_REC; i++) rec_bank[i*REC_W +: REC_W] = $urandom;
      issue(good, enc, 1'($urandom), 2'($urandom), wd, 11'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule